// File: doc/BRIEF.md
# Four-Mode Power Mode Controller

This block steps a device between four operating levels (Active, Power Save, Idle and Halt). For the level in force it drives the fast oscillator enable, the PLL enable, the system clock source select and gate, the slow clock gate, the timer/watchdog clock gate and two auxiliary clock gates. The oscillators, the PLL and the glitch-free clock multiplexers are outside the block. They appear only as enable and select outputs, plus an oscillator-ready input.

Software programs the block through three small registers: a control register, a status register and a wake-enable register. A write to the control register in Active or Power Save also requests a new level. An interrupt, or any wake event whose enable bit is set, brings the block back to Active from any reduced level. On the way back the fast oscillator starts first. The system clock stays on the slow clock until the oscillator reports ready or a settle counter runs out. A separate CPU wait request holds the CPU stalled until the next interrupt, without touching the level.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the level is Active, the fast oscillator is on, the system clock selects the main clock (code 00), the CPU is not stalled, the error flag is clear and all control bits are 0.
- R2: In Active the fast oscillator, system clock gate, slow clock gate and timer clock gate are all on. The system clock select is 01 (divided PLL) when both the PLL-on bit (control bit 3) and the PLL-select bit (control bit 7) are set, and 00 (main clock) otherwise.
- R3: In Power Save the system clock select is 10 (slow clock) with the system gate on, and the timer and slow gates stay on. The fast oscillator is off exactly when the stored oscillator-off bit (control bit 2) is set.
- R4: In Idle the system clock gate is off and the timer and slow gates are on. The fast oscillator follows the oscillator-off bit, and the PLL enable is the PLL-on bit ANDed with the oscillator enable.
- R5: In Halt the fast oscillator, PLL, system, slow, timer and both auxiliary gates are all off.
- R6: The slow clock source bit is control bit 4 (1 = divided main clock). A control write that sets both bit 2 and bit 4 stores bit 2 as 0 and sets the sticky error flag (status bit 2).
- R7: Writing status (address 1) with bit 2 set clears the error flag. Status reads return the level code in bits 1:0 and the error flag in bit 2.
- R8: Auxiliary gate i (control bits 5 and 6) is on only when its bit is set, the fast oscillator is on and no wake-up settle is in progress.
- R9: The slow source select output always equals control bit 4.
- R10: An interrupt, or a wake event whose bit is set in the wake-enable register (address 2), moves Power Save, Idle or Halt to a settle phase on the next edge. The settle phase reads level 00, turns the fast oscillator on and keeps the system clock on select 10. It ends after oscillator ready or STAB_CYCLES cycles, when the Active selection takes over.
- R11: A wait request sets the CPU stall on the next edge and an interrupt clears it on the next edge, with the interrupt taking priority. Neither changes the level by itself.
- R12: The level field (control bits 1:0: 00 Active, 01 Power Save, 10 Idle, 11 Halt) acts only in Active or Power Save. A write from Power Save with 00 starts a settle. Wake events whose enable bit is clear have no effect.
- R13: The level output and status bits 1:0 read 00 in Active and during a settle, 01 in Power Save, 10 in Idle and 11 in Halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address (0 control, 1 status, 2 wake enable) |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data |
| wake_evt | input | NWAKE | Wake-up event lines |
| irq | input | 1 | Interrupt request |
| wait_req | input | 1 | CPU wait request |
| hfosc_ready | input | 1 | Fast oscillator stable |
| hfosc_en | output | 1 | Fast oscillator enable |
| pll_en | output | 1 | PLL enable |
| sysclk_sel | output | 2 | System clock source select |
| sysclk_gate | output | 1 | System clock gate |
| slowclk_gate | output | 1 | Slow clock gate |
| slow_src_sel | output | 1 | Slow clock source select |
| twm_gate | output | 1 | Timer/watchdog clock gate |
| aux_gate | output | 2 | Auxiliary clock gates |
| cpu_stall | output | 1 | CPU stall |
| mode | output | 2 | Current level code |

## Verification
Directed sequences cover each level change, the rejected oscillator-off write, the error clear, the ignored level writes in Idle and a masked wake line. They also cover a settle with ready held low, which separates the counter exit from the ready exit, and a wait/interrupt pair. Random register writes, wake lines, interrupts and ready pulses then run against a cycle model. This mix reaches pairings that directed cases skip: an interrupt in the same cycle as a level write, guard writes while the oscillator is already off, and auxiliary enables during a settle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      ST_ACT  = 3'd0,
      ST_PS   = 3'd1,
      ST_IDLE = 3'd2,
      ST_HALT = 3'd3,
      ST_WAKE = 3'd4
   } pmc_state_e;

   localparam logic [1:0] MODE_ACT  = 2'b00;
   localparam logic [1:0] MODE_PS   = 2'b01;
   localparam logic [1:0] MODE_IDLE = 2'b10;
   localparam logic [1:0] MODE_HALT = 2'b11;

   localparam logic [1:0] SCLK_MAIN = 2'b00;
   localparam logic [1:0] SCLK_PLL  = 2'b01;
   localparam logic [1:0] SCLK_SLOW = 2'b10;

   localparam int NAUX = 2;

   localparam int B_OSC_OFF  = 2;
   localparam int B_PLL_ON   = 3;
   localparam int B_SLOW_DIV = 4;
   localparam int B_AUX0     = 5;
   localparam int B_SYS_PLL  = 7;
   localparam int B_ERR      = 2;

   typedef struct packed {
      logic            sys_pll;
      logic [NAUX-1:0] aux_en;
      logic            slow_div;
      logic            pll_on;
      logic            osc_off;
   } pmc_cfg_t;

   function automatic logic [1:0] state_code(pmc_state_e s);
      logic [1:0] c;
      case (s)
         ST_PS:   c = MODE_PS;
         ST_IDLE: c = MODE_IDLE;
         ST_HALT: c = MODE_HALT;
         default: c = MODE_ACT;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
   import pmc_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int NWAKE  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [1:0]        cur_code,
   output logic [DATA_W-1:0] rdata,
   output pmc_cfg_t          cfg,
   output logic [NWAKE-1:0]  wake_en,
   output logic              mode_wr,
   output logic [1:0]        mode_req
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(2);

   logic     err_q;
   logic     wr_ctrl, wr_stat, wr_wen;
   logic     bad_off;
   pmc_cfg_t cfg_q;

   assign wr_ctrl = wr && (waddr == A_CTRL);
   assign wr_stat = wr && (waddr == A_STAT);
   assign wr_wen  = wr && (waddr == A_WEN);
   assign bad_off = wdata[B_OSC_OFF] && wdata[B_SLOW_DIV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         err_q   <= 1'b0;
         wake_en <= '0;
      end else begin
         if (wr_ctrl) begin
            cfg_q.osc_off  <= wdata[B_OSC_OFF] && !wdata[B_SLOW_DIV];
            cfg_q.pll_on   <= wdata[B_PLL_ON];
            cfg_q.slow_div <= wdata[B_SLOW_DIV];
            cfg_q.aux_en   <= wdata[B_AUX0 +: NAUX];
            cfg_q.sys_pll  <= wdata[B_SYS_PLL];
         end
         if (wr_ctrl && bad_off) begin
            err_q <= 1'b1;
         end else if (wr_stat && wdata[B_ERR]) begin
            err_q <= 1'b0;
         end
         if (wr_wen) begin
            wake_en <= wdata[NWAKE-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (raddr == A_CTRL) begin
         rdata[B_OSC_OFF]       = cfg_q.osc_off;
         rdata[B_PLL_ON]        = cfg_q.pll_on;
         rdata[B_SLOW_DIV]      = cfg_q.slow_div;
         rdata[B_AUX0 +: NAUX]  = cfg_q.aux_en;
         rdata[B_SYS_PLL]       = cfg_q.sys_pll;
      end else if (raddr == A_STAT) begin
         rdata[1:0]   = cur_code;
         rdata[B_ERR] = err_q;
      end else if (raddr == A_WEN) begin
         rdata[NWAKE-1:0] = wake_en;
      end
   end

   assign cfg      = cfg_q;
   assign mode_wr  = wr_ctrl;
   assign mode_req = wdata[1:0];
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
#(
   parameter int NWAKE       = 4,
   parameter int STAB_CYCLES = 16,
   parameter bit USE_READY   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [1:0]       mode_req,
   input  logic [NWAKE-1:0] wake_evt,
   input  logic [NWAKE-1:0] wake_en,
   input  logic             irq,
   input  logic             hfosc_ready,
   output pmc_state_e       state
);
   localparam int              CNT_W    = $clog2(STAB_CYCLES) + 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

   pmc_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic             wake_hit, rdy_ok, settled;

   assign wake_hit = irq || (|(wake_evt & wake_en));

   generate
      if (USE_READY) begin : g_ready_exit
         assign rdy_ok = hfosc_ready;
      end else begin : g_count_only
         assign rdy_ok = 1'b0;
      end
   endgenerate

   assign settled = rdy_ok || (cnt_q == CNT_LAST);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_ACT: begin
            if (mode_wr) begin
               case (mode_req)
                  MODE_PS:   st_d = ST_PS;
                  MODE_IDLE: st_d = ST_IDLE;
                  MODE_HALT: st_d = ST_HALT;
                  default:   st_d = ST_ACT;
               endcase
            end
         end
         ST_PS: begin
            if (wake_hit) begin
               st_d = ST_WAKE;
            end else if (mode_wr) begin
               case (mode_req)
                  MODE_ACT:  st_d = ST_WAKE;
                  MODE_IDLE: st_d = ST_IDLE;
                  MODE_HALT: st_d = ST_HALT;
                  default:   st_d = ST_PS;
               endcase
            end
         end
         ST_IDLE, ST_HALT: begin
            if (wake_hit) st_d = ST_WAKE;
         end
         ST_WAKE: begin
            if (settled) st_d = ST_ACT;
         end
         default: st_d = ST_ACT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_ACT;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q != ST_WAKE) begin
            cnt_q <= '0;
         end else if (!settled) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign state = st_q;
endmodule

// File: rtl/pmc_clkout.sv
module pmc_clkout
   import pmc_pkg::*;
(
   input  pmc_state_e      state,
   input  pmc_cfg_t        cfg,
   output logic            hfosc_en,
   output logic            pll_en,
   output logic [1:0]      sysclk_sel,
   output logic            sysclk_gate,
   output logic            slowclk_gate,
   output logic            slow_src_sel,
   output logic            twm_gate,
   output logic [NAUX-1:0] aux_gate
);
   logic osc_on, halted, main_live;

   always_comb begin
      unique case (state)
         ST_ACT, ST_WAKE: osc_on = 1'b1;
         ST_HALT:         osc_on = 1'b0;
         default:         osc_on = !cfg.osc_off;
      endcase
   end

   assign halted    = (state == ST_HALT);
   assign main_live = osc_on && (state != ST_WAKE);

   assign hfosc_en     = osc_on;
   assign pll_en       = cfg.pll_on && osc_on && !halted;
   assign sysclk_gate  = (state == ST_ACT) || (state == ST_PS) || (state == ST_WAKE);
   assign slowclk_gate = !halted;
   assign twm_gate     = !halted;
   assign slow_src_sel = cfg.slow_div;

   always_comb begin
      if (state == ST_ACT) begin
         sysclk_sel = (cfg.sys_pll && cfg.pll_on) ? SCLK_PLL : SCLK_MAIN;
      end else begin
         sysclk_sel = SCLK_SLOW;
      end
   end

   generate
      for (genvar i = 0; i < NAUX; i++) begin : g_aux
         assign aux_gate[i] = cfg.aux_en[i] && main_live;
      end
   endgenerate
endmodule

// File: rtl/pmc_stall.sv
module pmc_stall (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_req,
   input  logic irq,
   output logic cpu_stall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_stall <= 1'b0;
      end else if (irq) begin
         cpu_stall <= 1'b0;
      end else if (wait_req) begin
         cpu_stall <= 1'b1;
      end
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int NWAKE       = 4,
   parameter int STAB_CYCLES = 16,
   parameter bit USE_READY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NWAKE-1:0]  wake_evt,
   input  logic              irq,
   input  logic              wait_req,
   input  logic              hfosc_ready,
   output logic              hfosc_en,
   output logic              pll_en,
   output logic [1:0]        sysclk_sel,
   output logic              sysclk_gate,
   output logic              slowclk_gate,
   output logic              slow_src_sel,
   output logic              twm_gate,
   output logic [1:0]        aux_gate,
   output logic              cpu_stall,
   output logic [1:0]        mode
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (NWAKE < 1 || NWAKE > DATA_W) begin : g_bad_wake
         $error("NWAKE must be between 1 and DATA_W");
      end
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("STAB_CYCLES must be at least 1");
      end
   endgenerate

   pmc_state_e       state;
   pmc_cfg_t         cfg;
   logic [NWAKE-1:0] wake_en;
   logic             mode_wr;
   logic [1:0]       mode_req;
   logic [1:0]       cur_code;

   assign cur_code = state_code(state);
   assign mode     = cur_code;

   pmc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWAKE(NWAKE)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .waddr    (reg_waddr),
      .wdata    (reg_wdata),
      .raddr    (reg_raddr),
      .cur_code (cur_code),
      .rdata    (reg_rdata),
      .cfg      (cfg),
      .wake_en  (wake_en),
      .mode_wr  (mode_wr),
      .mode_req (mode_req)
   );

   pmc_fsm #(.NWAKE(NWAKE), .STAB_CYCLES(STAB_CYCLES), .USE_READY(USE_READY)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (mode_wr),
      .mode_req    (mode_req),
      .wake_evt    (wake_evt),
      .wake_en     (wake_en),
      .irq         (irq),
      .hfosc_ready (hfosc_ready),
      .state       (state)
   );

   pmc_clkout u_clkout (
      .state        (state),
      .cfg          (cfg),
      .hfosc_en     (hfosc_en),
      .pll_en       (pll_en),
      .sysclk_sel   (sysclk_sel),
      .sysclk_gate  (sysclk_gate),
      .slowclk_gate (slowclk_gate),
      .slow_src_sel (slow_src_sel),
      .twm_gate     (twm_gate),
      .aux_gate     (aux_gate)
   );

   pmc_stall u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_req  (wait_req),
      .irq       (irq),
      .cpu_stall (cpu_stall)
   );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       irq,
   input logic       wait_req,
   input logic       hfosc_en,
   input logic       pll_en,
   input logic [1:0] sysclk_sel,
   input logic       sysclk_gate,
   input logic       slowclk_gate,
   input logic       slow_src_sel,
   input logic       twm_gate,
   input logic [1:0] aux_gate,
   input logic       cpu_stall,
   input logic [1:0] mode
);
   p_reset_active_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (mode == 2'b00 && hfosc_en && !cpu_stall));

   p_active_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (hfosc_en && sysclk_gate && twm_gate && slowclk_gate));

   p_psave_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> (sysclk_sel == 2'b10 && sysclk_gate && twm_gate));

   p_idle_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (!sysclk_gate && twm_gate && slowclk_gate));

   p_halt_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> (!hfosc_en && !pll_en && !sysclk_gate &&
                           !slowclk_gate && !twm_gate && aux_gate == 2'b00));

   p_osc_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hfosc_en && mode != 2'b11) |-> !slow_src_sel);

   p_aux_needs_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_gate != 2'b00) |-> hfosc_en);

   p_wake_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && mode != 2'b00) |=> (mode == 2'b00 && hfosc_en));

   p_stall_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !irq) |=> cpu_stall);

   p_stall_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !cpu_stall);
endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq          (irq),
   .wait_req     (wait_req),
   .hfosc_en     (hfosc_en),
   .pll_en       (pll_en),
   .sysclk_sel   (sysclk_sel),
   .sysclk_gate  (sysclk_gate),
   .slowclk_gate (slowclk_gate),
   .slow_src_sel (slow_src_sel),
   .twm_gate     (twm_gate),
   .aux_gate     (aux_gate),
   .cpu_stall    (cpu_stall),
   .mode         (mode)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int STAB       = 16;
   localparam int NW         = 4;
   localparam int WDOG       = 150000;

   // bench model state codes
   localparam int S_ACT = 0, S_PS = 1, S_IDLE = 2, S_HALT = 3, S_WAKE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_waddr = '0;
   logic [7:0] reg_wdata = '0;
   logic [1:0] reg_raddr = '0;
   logic [7:0] reg_rdata;
   logic [NW-1:0] wake_evt = '0;
   logic       irq = 1'b0, wait_req = 1'b0, hfosc_ready = 1'b0;
   logic       hfosc_en, pll_en, sysclk_gate, slowclk_gate, slow_src_sel, twm_gate, cpu_stall;
   logic [1:0] sysclk_sel, aux_gate, mode;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   // model
   int         m_st = S_ACT;
   int         m_cnt = 0;
   logic       m_off = 0, m_pll = 0, m_div = 0, m_spll = 0, m_err = 0, m_stall = 0;
   logic [1:0] m_aux = '0;
   logic [NW-1:0] m_wen = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.NWAKE(NW), .STAB_CYCLES(STAB)) u_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .wake_evt(wake_evt), .irq(irq), .wait_req(wait_req), .hfosc_ready(hfosc_ready),
      .hfosc_en(hfosc_en), .pll_en(pll_en), .sysclk_sel(sysclk_sel),
      .sysclk_gate(sysclk_gate), .slowclk_gate(slowclk_gate),
      .slow_src_sel(slow_src_sel), .twm_gate(twm_gate), .aux_gate(aux_gate),
      .cpu_stall(cpu_stall), .mode(mode)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int e_osc();
      if (m_st == S_ACT || m_st == S_WAKE) return 1;
      if (m_st == S_HALT) return 0;
      return m_off ? 0 : 1;
   endfunction
   function automatic int e_pll();
      return (m_pll && e_osc() == 1 && m_st != S_HALT) ? 1 : 0;
   endfunction
   function automatic int e_sel();
      if (m_st == S_ACT) return (m_spll && m_pll) ? 1 : 0;
      return 2;
   endfunction
   function automatic int e_sysg();
      return (m_st == S_ACT || m_st == S_PS || m_st == S_WAKE) ? 1 : 0;
   endfunction
   function automatic int e_aux();
      if (e_osc() == 1 && m_st != S_WAKE) return int'(m_aux);
      return 0;
   endfunction
   function automatic int e_mode();
      return (m_st == S_WAKE) ? 0 : m_st;
   endfunction
   function automatic int e_rdata();
      case (reg_raddr)
         2'd0: return int'({m_spll, m_aux, m_div, m_pll, m_off, 2'b00});
         2'd1: return int'({m_err, 2'(e_mode())});
         2'd2: return int'(m_wen);
         default: return 0;
      endcase
   endfunction
   function automatic string st_tag();
      case (m_st)
         S_ACT:  return "R2";
         S_PS:   return "R3";
         S_IDLE: return "R4";
         S_HALT: return "R5";
         default: return "R10";
      endcase
   endfunction

   task automatic model_step();
      bit wk;
      int nx;
      wk = irq || (|(wake_evt & m_wen));
      nx = m_st;
      case (m_st)
         S_ACT: if (reg_wr && reg_waddr == 2'd0 && reg_wdata[1:0] != 2'd0) nx = int'(reg_wdata[1:0]);
         S_PS: begin
            if (wk) nx = S_WAKE;
            else if (reg_wr && reg_waddr == 2'd0)
               nx = (reg_wdata[1:0] == 2'd0) ? S_WAKE : int'(reg_wdata[1:0]);
         end
         S_IDLE, S_HALT: if (wk) nx = S_WAKE;
         default: if (hfosc_ready || m_cnt == STAB - 1) nx = S_ACT;
      endcase
      if (m_st != S_WAKE) m_cnt = 0;
      else if (!(hfosc_ready || m_cnt == STAB - 1)) m_cnt++;
      m_st = nx;
      if (reg_wr && reg_waddr == 2'd0) begin
         m_off  = reg_wdata[2] && !reg_wdata[4];
         m_pll  = reg_wdata[3];
         m_div  = reg_wdata[4];
         m_aux  = reg_wdata[6:5];
         m_spll = reg_wdata[7];
         if (reg_wdata[2] && reg_wdata[4]) m_err = 1;
      end
      if (reg_wr && reg_waddr == 2'd1 && reg_wdata[2]) m_err = 0;
      if (reg_wr && reg_waddr == 2'd2) m_wen = reg_wdata[NW-1:0];
      if (irq) m_stall = 0;
      else if (wait_req) m_stall = 1;
   endtask

   task automatic check_all();
      string t;
      t = st_tag();
      chk(t, "hfosc_en", int'(hfosc_en), e_osc());
      chk(t, "pll_en", int'(pll_en), e_pll());
      chk(t, "sysclk_sel", int'(sysclk_sel), e_sel());
      chk(t, "sysclk_gate", int'(sysclk_gate), e_sysg());
      chk(t, "twm_gate", int'(twm_gate), (m_st == S_HALT) ? 0 : 1);
      chk(t, "slowclk_gate", int'(slowclk_gate), (m_st == S_HALT) ? 0 : 1);
      chk("R8", "aux_gate", int'(aux_gate), e_aux());
      chk("R9", "slow_src_sel", int'(slow_src_sel), int'(m_div));
      chk("R11", "cpu_stall", int'(cpu_stall), int'(m_stall));
      chk("R13", "mode", int'(mode), e_mode());
      chk("R7", "reg_rdata", int'(reg_rdata), e_rdata());
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      cyc();
      reg_wr = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset values
      reg_raddr = 2'd1;
      #1;
      chk("R1", "mode", int'(mode), 0);
      chk("R1", "hfosc_en", int'(hfosc_en), 1);
      chk("R1", "sysclk_sel", int'(sysclk_sel), 0);
      chk("R1", "cpu_stall", int'(cpu_stall), 0);
      chk("R1", "status", int'(reg_rdata), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc();

      // R2 PLL selection in Active
      wr(2'd0, 8'h88);
      chk("R2", "sysclk_sel pll", int'(sysclk_sel), 1);
      wr(2'd0, 8'h80);
      chk("R2", "sysclk_sel no pll", int'(sysclk_sel), 0);

      // R6 rejected oscillator-off with divided slow source, go to Power Save
      reg_raddr = 2'd1;
      wr(2'd0, 8'h15);
      chk("R6", "hfosc_en kept", int'(hfosc_en), 1);
      chk("R6", "error flag", int'(reg_rdata[2]), 1);
      chk("R3", "mode", int'(mode), 1);
      // R7 clear
      wr(2'd1, 8'h04);
      chk("R7", "error cleared", int'(reg_rdata[2]), 0);

      // R3 legal oscillator-off in Power Save, aux requested
      wr(2'd0, 8'h65);
      chk("R3", "hfosc_en off", int'(hfosc_en), 0);
      chk("R8", "aux forced off", int'(aux_gate), 0);

      // R4 Idle, then ignored level write and masked wake (R12)
      wr(2'd0, 8'h0E);
      chk("R4", "sysclk_gate", int'(sysclk_gate), 0);
      wr(2'd0, 8'h00);
      chk("R12", "idle kept on level write", int'(mode), 2);
      wake_evt = 4'b0101;
      cyc();
      chk("R12", "masked wake ignored", int'(mode), 2);
      wake_evt = '0;

      // R10 interrupt wake with ready low: STAB settle cycles
      irq = 1'b1;
      cyc();
      irq = 1'b0;
      chk("R10", "settle mode", int'(mode), 0);
      chk("R10", "settle sel slow", int'(sysclk_sel), 2);
      for (int i = 1; i < STAB; i++) cyc();
      chk("R10", "last settle sel", int'(sysclk_sel), 2);
      cyc();
      chk("R10", "back on main", int'(sysclk_sel), 0);

      // R5 Halt then enabled wake line with ready high
      wr(2'd2, 8'h02);
      wr(2'd0, 8'h6B);
      chk("R5", "halt gates", int'({hfosc_en, twm_gate, slowclk_gate, aux_gate}), 0);
      wake_evt = 4'b0010; hfosc_ready = 1'b1;
      cyc();
      wake_evt = '0;
      chk("R10", "settle osc on", int'(hfosc_en), 1);
      cyc();
      chk("R10", "active after ready", int'(mode), 0);
      chk("R8", "aux back", int'(aux_gate), 3);
      hfosc_ready = 1'b0;

      // R11 wait / interrupt without level change
      wait_req = 1'b1;
      cyc();
      wait_req = 1'b0;
      chk("R11", "stall set", int'(cpu_stall), 1);
      chk("R11", "mode unchanged", int'(mode), 0);
      irq = 1'b1;
      cyc();
      irq = 1'b0;
      chk("R11", "stall cleared", int'(cpu_stall), 0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         reg_wr      = ($urandom % 4) == 0;
         reg_waddr   = 2'($urandom % 4);
         reg_wdata   = 8'($urandom);
         reg_raddr   = 2'($urandom % 4);
         wake_evt    = (($urandom % 12) == 0) ? NW'($urandom) : '0;
         irq         = ($urandom % 25) == 0;
         wait_req    = ($urandom % 8) == 0;
         hfosc_ready = ($urandom % 3) == 0;
         cyc();
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule